// File: doc/BRIEF.md
# Three-Hand Ring Page Replacement Controller

This block decides which page leaves a fixed-size resident set when a new page must come in. It keeps a ring of slots. Each occupied slot holds a page tag and one of three kinds: hot resident, cold resident, or ghost. A ghost is a cold page that has already been evicted, kept only as a history record. Every slot also carries a reference bit and a test-period flag. A request whose tag is resident only marks the page as referenced. Any other request starts a miss sequence, in which three independent pointers walk the ring clockwise, one slot per clock.

The cold pointer looks for a resident cold page to evict. The hot pointer lowers the number of hot pages whenever it is above a fixed target. The test pointer removes ghost records once there are more of them than the resident capacity, and it ends the test periods of the cold pages it passes. A miss on a tag that still has a ghost record shows that the page was reused within a short distance, so that page comes back in as hot.

The surrounding cache controller presents a request when `ready` is high. It then waits for the single-cycle `done` pulse, which carries the hit/miss result and, when a page was evicted, the victim tag. The data movement itself is done elsewhere.

Top module: `cpro_ring_ctrl`

## Requirements
- R1: After reset `ready` is 1, `done` is 0, no page is resident, and all three pointers stand at slot 0. The first request for any tag is therefore a miss with no eviction.
- R2: A request for a resident tag (hot or cold) produces `done`=1, `hit`=1 and `evict`=0 in the cycle after it is accepted. Its only effect is to set that page's reference bit. No pointer moves.
- R3: A miss while fewer than RES_CAP pages are resident inserts the new page as cold resident, with its reference bit clear and its test period open. It reports `done`=1 with `hit`=0 and `evict`=0. `ready` is 0 from the cycle after acceptance until `done`.
- R4: A miss while RES_CAP pages are resident evicts exactly one resident cold page. The cold pointer scans slots in ascending index order, wrapping at the top, starting where it last stopped. The first cold page it reaches with the reference bit clear is the victim. The victim's tag appears on `victim_tag` with `evict`=1 in the `done` cycle.
- R5: When the cold pointer reaches a cold page whose reference bit is set, that page is not evicted. If it is in its test period it becomes hot. Otherwise its bit is cleared and a new test period starts.
- R6: During the eviction search and after insertion, the hot pointer steps in place of the cold pointer while the hot count exceeds HOT_MAX. A hot page with its bit set has the bit cleared. A hot page with its bit clear becomes cold, with no test period. Whenever `ready` is 1, the hot count is at most HOT_MAX.
- R7: An evicted page that is still in its test period stays as a ghost record. A miss on a tag that has a ghost record removes the record and inserts the page as hot.
- R8: While ghost records outnumber RES_CAP, or no slot is free, the test pointer steps clockwise. It drops the first ghost it reaches and clears the test flag of any cold resident page it passes.
- R9: A tag is held in at most one slot of the ring.
- R10: Each pointer advances one slot per cycle, and every miss reaches `done` in a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `ready` is 1 |
| req_tag | input | TAG_W | Tag of the requested page |
| ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | With `done`: the page was resident |
| evict | output | 1 | With `done`: a resident page was evicted |
| victim_tag | output | TAG_W | With `done` and `evict`: tag of the evicted page |

## Verification
A slot with the wrong kind or a stale reference bit stays hidden until the cold pointer reaches it. The error then shows up as a wrong `victim_tag`, or as a wrong hit or miss on a later request for a promoted or dropped tag. That can take a full sweep of the ring, which at most is a few dozen requests in a small configuration. Long request streams with repeated and looping tags are therefore compared against an independent model, so that slow drift in pointer positions or ghost bookkeeping shows up as a victim mismatch. Count and uniqueness errors are caught earlier, in the cycle they appear, by invariants on the internal census.

// File: rtl/cpro_pkg.sv
`timescale 1ns/1ps
package cpro_pkg;

    // Slot kind: empty, hot resident, cold resident, ghost (evicted history)
    typedef enum logic [1:0] {
        PG_EMPTY = 2'd0,
        PG_HOT   = 2'd1,
        PG_COLD  = 2'd2,
        PG_GHOST = 2'd3
    } pg_kind_e;

    typedef struct packed {
        pg_kind_e kind;
        logic     refb;
        logic     tst;
    } meta_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_EVICT = 2'd1,
        PH_ROOM  = 2'd2,
        PH_TRIM  = 2'd3
    } phase_e;

    function automatic meta_t mk_meta(input pg_kind_e k, input logic r, input logic t);
        meta_t m;
        m.kind = k;
        m.refb = r;
        m.tst  = t;
        return m;
    endfunction

endpackage

// File: rtl/cpro_lookup.sv
`timescale 1ns/1ps
module cpro_lookup
    import cpro_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int TAG_W = 8,
    localparam int IW   = $clog2(SLOTS)
) (
    input  meta_t [SLOTS-1:0]            meta,
    input  logic  [SLOTS-1:0][TAG_W-1:0] tags,
    input  logic  [TAG_W-1:0]            key,
    output logic  [SLOTS-1:0]            match_vec,
    output logic                         res_hit,
    output logic  [IW-1:0]               res_idx,
    output logic                         nr_hit,
    output logic  [IW-1:0]               nr_idx
);

    logic [SLOTS-1:0] ghost_vec;

    // One comparator per slot
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match_vec[g] = (meta[g].kind != PG_EMPTY) && (tags[g] == key);
        assign ghost_vec[g] = (meta[g].kind == PG_GHOST);
    end

    // Lowest matching index wins (only one can match when tags are unique)
    always_comb begin
        res_hit = 1'b0;
        res_idx = '0;
        nr_hit  = 1'b0;
        nr_idx  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                if (ghost_vec[i]) begin
                    nr_hit = 1'b1;
                    nr_idx = IW'(i);
                end else begin
                    res_hit = 1'b1;
                    res_idx = IW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/cpro_census.sv
`timescale 1ns/1ps
module cpro_census
    import cpro_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int IW   = $clog2(SLOTS),
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  meta_t [SLOTS-1:0] meta,
    output logic  [CW-1:0]    res_cnt,
    output logic  [CW-1:0]    hot_cnt,
    output logic  [CW-1:0]    nr_cnt,
    output logic              free_any,
    output logic  [IW-1:0]    free_idx
);

    always_comb begin
        res_cnt  = '0;
        hot_cnt  = '0;
        nr_cnt   = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            unique case (meta[i].kind)
                PG_HOT: begin
                    hot_cnt = hot_cnt + CW'(1);
                    res_cnt = res_cnt + CW'(1);
                end
                PG_COLD:  res_cnt = res_cnt + CW'(1);
                PG_GHOST: nr_cnt  = nr_cnt + CW'(1);
                PG_EMPTY: begin
                    free_any = 1'b1;
                    free_idx = IW'(i);
                end
            endcase
        end
    end

endmodule

// File: rtl/cpro_ring_ctrl.sv
`timescale 1ns/1ps
module cpro_ring_ctrl
    import cpro_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int RES_CAP = 8,
    parameter int HOT_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    output logic             ready,
    output logic             done,
    output logic             hit,
    output logic             evict,
    output logic [TAG_W-1:0] victim_tag
);

    localparam int SLOTS = 2 * RES_CAP;
    localparam int IW    = $clog2(SLOTS);
    localparam int CW    = $clog2(SLOTS + 1);

    typedef struct packed {
        phase_e                        phase;
        meta_t [SLOTS-1:0]             meta;
        logic  [SLOTS-1:0][TAG_W-1:0]  tags;
        logic  [IW-1:0]                hh;
        logic  [IW-1:0]                hc;
        logic  [IW-1:0]                ht;
        logic  [TAG_W-1:0]             new_tag;
        logic                          new_hot;
        logic                          pend_ev;
        logic  [TAG_W-1:0]             pend_vt;
        logic                          done;
        logic                          hit;
        logic                          evict;
        logic  [TAG_W-1:0]             vtag;
    } regs_t;

    regs_t q, n;

    logic [SLOTS-1:0] match_vec;
    logic             lk_res_hit, lk_nr_hit;
    logic [IW-1:0]    lk_res_idx, lk_nr_idx;
    logic [CW-1:0]    res_cnt, hot_cnt, nr_cnt;
    logic             free_any;
    logic [IW-1:0]    free_idx;

    cpro_lookup #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_lookup (
        .meta      (q.meta),
        .tags      (q.tags),
        .key       (req_tag),
        .match_vec (match_vec),
        .res_hit   (lk_res_hit),
        .res_idx   (lk_res_idx),
        .nr_hit    (lk_nr_hit),
        .nr_idx    (lk_nr_idx)
    );

    cpro_census #(.SLOTS(SLOTS)) u_census (
        .meta     (q.meta),
        .res_cnt  (res_cnt),
        .hot_cnt  (hot_cnt),
        .nr_cnt   (nr_cnt),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    function automatic logic [IW-1:0] adv(input logic [IW-1:0] p);
        return (p == IW'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    logic  hot_over;
    logic  hot_run;
    meta_t m_h, m_c, m_t;

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        n.hit    = 1'b0;
        n.evict  = 1'b0;
        hot_over = (hot_cnt > CW'(HOT_MAX));
        hot_run  = hot_over && (q.phase == PH_EVICT || q.phase == PH_TRIM);
        m_h      = q.meta[q.hh];
        m_c      = q.meta[q.hc];
        m_t      = q.meta[q.ht];

        // Hot pointer: shared by the eviction search and the final trim
        if (hot_run) begin
            n.hh = adv(q.hh);
            if (m_h.kind == PG_HOT) begin
                if (m_h.refb) n.meta[q.hh] = mk_meta(PG_HOT, 1'b0, 1'b0);
                else          n.meta[q.hh] = mk_meta(PG_COLD, 1'b0, 1'b0);
            end
        end

        unique case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (lk_res_hit) begin
                        n.meta[lk_res_idx].refb = 1'b1;
                        n.done = 1'b1;
                        n.hit  = 1'b1;
                    end else begin
                        n.new_tag = req_tag;
                        n.new_hot = lk_nr_hit;
                        n.pend_ev = 1'b0;
                        if (lk_nr_hit) n.meta[lk_nr_idx] = mk_meta(PG_EMPTY, 1'b0, 1'b0);
                        n.phase = (res_cnt == CW'(RES_CAP)) ? PH_EVICT : PH_ROOM;
                    end
                end
            end
            PH_EVICT: begin
                if (!hot_over) begin
                    n.hc = adv(q.hc);
                    if (m_c.kind == PG_COLD) begin
                        if (m_c.refb && m_c.tst) begin
                            n.meta[q.hc] = mk_meta(PG_HOT, 1'b0, 1'b0);
                        end else if (m_c.refb) begin
                            n.meta[q.hc] = mk_meta(PG_COLD, 1'b0, 1'b1);
                        end else begin
                            n.pend_ev = 1'b1;
                            n.pend_vt = q.tags[q.hc];
                            n.meta[q.hc] = m_c.tst ? mk_meta(PG_GHOST, 1'b0, 1'b0)
                                                   : mk_meta(PG_EMPTY, 1'b0, 1'b0);
                            n.phase = PH_ROOM;
                        end
                    end
                end
            end
            PH_ROOM: begin
                if (nr_cnt > CW'(RES_CAP) || !free_any) begin
                    n.ht = adv(q.ht);
                    if (m_t.kind == PG_GHOST) begin
                        n.meta[q.ht] = mk_meta(PG_EMPTY, 1'b0, 1'b0);
                    end else if (m_t.kind == PG_COLD && m_t.tst) begin
                        n.meta[q.ht].tst = 1'b0;
                    end
                end else begin
                    n.tags[free_idx] = q.new_tag;
                    n.meta[free_idx] = q.new_hot ? mk_meta(PG_HOT, 1'b0, 1'b0)
                                                 : mk_meta(PG_COLD, 1'b0, 1'b1);
                    n.phase = PH_TRIM;
                end
            end
            PH_TRIM: begin
                if (!hot_over) begin
                    n.done  = 1'b1;
                    n.evict = q.pend_ev;
                    n.vtag  = q.pend_vt;
                    n.phase = PH_IDLE;
                end
            end
            default: n.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign ready      = (q.phase == PH_IDLE);
    assign done       = q.done;
    assign hit        = q.hit;
    assign evict      = q.evict;
    assign victim_tag = q.vtag;

endmodule

// File: rtl/cpro_ring_chk.sv
`timescale 1ns/1ps
module cpro_ring_chk #(
    parameter int RES_CAP = 8,
    parameter int HOT_MAX = 4,
    parameter int SLOTS   = 16,
    parameter int CW      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             ready,
    input logic             done,
    input logic             hit,
    input logic             evict,
    input logic [CW-1:0]    res_cnt,
    input logic [CW-1:0]    hot_cnt,
    input logic [CW-1:0]    nr_cnt,
    input logic [SLOTS-1:0] match_vec
);

    // R2
    accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> ((done && hit) || !ready));

    // R2
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (done && !evict));

    // R4
    evict_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict |-> done);

    // R3
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R3
    res_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_cnt <= CW'(RES_CAP));

    // R6
    hot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (hot_cnt <= CW'(HOT_MAX)));

    // R8
    ghost_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (nr_cnt <= CW'(RES_CAP)));

    // R9
    unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match_vec) <= 1);

endmodule

bind cpro_ring_ctrl cpro_ring_chk #(
    .RES_CAP (RES_CAP),
    .HOT_MAX (HOT_MAX),
    .SLOTS   (SLOTS),
    .CW      (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .done      (done),
    .hit       (hit),
    .evict     (evict),
    .res_cnt   (res_cnt),
    .hot_cnt   (hot_cnt),
    .nr_cnt    (nr_cnt),
    .match_vec (match_vec)
);

// File: tb/cpro_ring_ctrl_bench.sv
`timescale 1ns/1ps
module cpro_ring_ctrl_bench;

    localparam int TW  = 4;
    localparam int RC  = 4;
    localparam int HM  = 2;
    localparam int SL  = 2 * RC;
    localparam int LIM = 64 * SL;

    localparam int K_EMPTY = 0;
    localparam int K_HOT   = 1;
    localparam int K_COLD  = 2;
    localparam int K_GHOST = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [TW-1:0] req_tag = '0;
    logic          ready, done, hit, evict;
    logic [TW-1:0] victim_tag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    cpro_ring_ctrl #(.TAG_W(TW), .RES_CAP(RC), .HOT_MAX(HM)) u_cpro_ring_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_tag    (req_tag),
        .ready      (ready),
        .done       (done),
        .hit        (hit),
        .evict      (evict),
        .victim_tag (victim_tag)
    );

    always #2 clk = ~clk;

    // Independent reference model of the ring
    int mk[SL];
    int mt[SL];
    bit mr[SL];
    bit ms[SL];
    int mhh, mhc, mht;

    // Results of the last access
    bit got_hit, got_ev;
    int got_vt, got_lat;
    bit e_hit, e_ev, e_gh;
    int e_vt;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cnt_kind(input int k);
        int c = 0;
        for (int i = 0; i < SL; i++) if (mk[i] == k) c++;
        return c;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < SL; i++) begin
            mk[i] = K_EMPTY; mt[i] = 0; mr[i] = 0; ms[i] = 0;
        end
        mhh = 0; mhc = 0; mht = 0;
    endtask

    task automatic m_hot_step();
        int p = mhh;
        mhh = (mhh + 1) % SL;
        if (mk[p] == K_HOT) begin
            if (mr[p]) mr[p] = 0;
            else begin mk[p] = K_COLD; mr[p] = 0; ms[p] = 0; end
        end
    endtask

    task automatic m_access(input int tg);
        int ri = -1;
        int gi = -1;
        int fi = -1;
        bit found = 0;
        for (int i = 0; i < SL; i++) begin
            if (mk[i] != K_EMPTY && mt[i] == tg) begin
                if (mk[i] == K_GHOST) gi = i; else ri = i;
            end
        end
        e_hit = 0; e_ev = 0; e_vt = 0; e_gh = (gi >= 0);
        if (ri >= 0) begin
            mr[ri] = 1; e_hit = 1;
        end else begin
            if (gi >= 0) mk[gi] = K_EMPTY;
            if (cnt_kind(K_HOT) + cnt_kind(K_COLD) == RC) begin
                while (!found) begin
                    if (cnt_kind(K_HOT) > HM) m_hot_step();
                    else begin
                        int p = mhc;
                        mhc = (mhc + 1) % SL;
                        if (mk[p] == K_COLD) begin
                            if (mr[p] && ms[p]) begin mk[p] = K_HOT; mr[p] = 0; ms[p] = 0; end
                            else if (mr[p]) begin mr[p] = 0; ms[p] = 1; end
                            else begin
                                e_ev = 1; e_vt = mt[p];
                                mk[p] = ms[p] ? K_GHOST : K_EMPTY;
                                mr[p] = 0; ms[p] = 0; found = 1;
                            end
                        end
                    end
                end
            end
            while (cnt_kind(K_GHOST) > RC || cnt_kind(K_EMPTY) == 0) begin
                int p = mht;
                mht = (mht + 1) % SL;
                if (mk[p] == K_GHOST) mk[p] = K_EMPTY;
                else if (mk[p] == K_COLD && ms[p]) ms[p] = 0;
            end
            for (int i = SL - 1; i >= 0; i--) if (mk[i] == K_EMPTY) fi = i;
            mt[fi] = tg; mr[fi] = 0;
            if (e_gh) begin mk[fi] = K_HOT; ms[fi] = 0; end
            else      begin mk[fi] = K_COLD; ms[fi] = 1; end
            while (cnt_kind(K_HOT) > HM) m_hot_step();
        end
    endtask

    // Drive one request, wait for done, compare with the model
    task automatic access(input int tg);
        string lbl;
        m_access(tg);
        @(negedge clk);
        req_valid = 1'b1;
        req_tag   = TW'(tg);
        @(negedge clk);
        req_valid = 1'b0;
        got_lat = 1;
        if (!e_hit) chk(ready == 1'b0, "R3 ready low during miss", int'(ready), 0);
        while (!done && got_lat < LIM) begin
            @(negedge clk);
            got_lat++;
        end
        got_hit = hit; got_ev = evict; got_vt = int'(victim_tag);
        chk(done == 1'b1, "R10 miss completes in bounded time", got_lat, LIM);
        if (e_hit) lbl = "R2 resident hit";
        else if (e_gh) lbl = "R7 ghost reuse";
        else if (e_ev) lbl = "R4/R5/R6/R8/R9 victim choice";
        else lbl = "R3 fill miss";
        chk(got_hit == e_hit, lbl, int'(got_hit), int'(e_hit));
        chk(got_ev == e_ev, lbl, int'(got_ev), int'(e_ev));
        if (e_ev) chk(got_vt == e_vt, lbl, got_vt, e_vt);
        if (e_hit) chk(got_lat == 1, "R2 hit latency", got_lat, 1);
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);

        // Directed sequence with hand-computed results
        for (int t = 1; t <= 4; t++) begin
            access(t);
            chk(!got_hit && !got_ev, "R1 R3 first access misses without eviction", int'(got_ev), 0);
        end
        access(1);
        chk(got_hit, "R2 hit on tag 1", int'(got_hit), 1);
        access(5);
        chk(got_ev && got_vt == 2, "R5 referenced tag 1 promoted, tag 2 evicted", got_vt, 2);
        access(2);
        chk(got_ev && got_vt == 3, "R7 ghost tag 2 returns, tag 3 evicted", got_vt, 3);
        access(3);
        chk(got_ev && got_vt == 4, "R4 R6 tag 4 evicted, hot trim", got_vt, 4);
        access(6);
        chk(got_ev && got_vt == 5, "R4 clockwise victim tag 5", got_vt, 5);
        access(7);
        chk(got_ev && got_vt == 6, "R4 pointer continues to tag 6", got_vt, 6);
        access(1);
        chk(got_hit, "R6 demoted tag 1 still resident", int'(got_hit), 1);

        // Loop one longer than the resident set
        for (int r = 0; r < 20; r++)
            for (int t = 8; t < 8 + RC + 1; t++) access(t);

        // Scan mixed with a small reused set
        for (int r = 0; r < 12; r++)
            for (int t = 0; t < 16; t++) begin
                access(t);
                access(1 + (t % 2));
            end

        // Exhaustive-style skewed pseudo-random stream
        begin
            logic [15:0] lf = 16'hACE1;
            for (int k = 0; k < 1500; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                access(lf[7] ? int'(lf[1:0]) : int'(lf[3:0]));
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        while (!finished && cycles < 180000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cycles, 180000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule